// File: doc/BRIEF.md
# Paired Actual/Reference Performance Counters

This block keeps two 64-bit up-counters for a single logical processor. Their ratio tells power-management software how much work the core really delivered against a fixed time base. The reference counter advances on a fixed-rate tick. The actual counter advances on a tick that tracks delivered performance. A throttle input suppresses that tick, so throttling and lowered operating points show up as a slower actual count. Both counters are frozen whenever the core-active (C0) input is low.

If either counter steps past all-ones, both counters clear in the same cycle and then keep counting. Software can tell that a wrap happened because the new readings are smaller than the ones it saved before. Each counter can be read and written on its own through a simple strobe-based register port. To open a measurement window, software writes zero to each counter in turn. A constant capability flag tells software that the pair exists.

Top module: `perf_ratio_counters`

## Requirements
- R1: A synchronous reset clears both counters to zero and clears the read-data output to zero.
- R2: The reference counter, at register address 0xE7, rises by exactly one on each clock edge where `active_i` and `ref_tick_i` are both high. In any other cycle it holds its value, unless it is written or cleared.
- R3: The actual counter, at register address 0xE8, rises by exactly one on each clock edge where `active_i` and `act_tick_i` are high and `throttle_i` is low. In any other cycle it holds its value, unless it is written or cleared.
- R4: While `active_i` is low, neither counter changes in response to any tick or throttle input.
- R5: When an increment would carry a counter past all-ones, both counters are zero after that clock edge. Counting then resumes from zero.
- R6: A write (`reg_wr_i` high with address 0xE7 or 0xE8) loads `reg_wdata_i` into the addressed counter at the next edge. If that counter would also have incremented in the same cycle, the increment is dropped.
- R7: When a write to one counter falls in the same cycle as an overflow of the other, the written counter takes the write data and only the other counter is cleared.
- R8: A read strobe (`reg_rd_i`) with a counter address makes `reg_rdata_o` show that counter's value as it was at the strobe edge. The value appears one cycle after the strobe and holds until the next read strobe.
- R9: A read of any address other than 0xE7 or 0xE8 returns zero. A write to any such address changes neither counter.
- R10: `cap_present_o` is 1 at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| active_i | input | 1 | Core is in the active (C0) state; gates both counters |
| ref_tick_i | input | 1 | Fixed-rate reference tick enable |
| act_tick_i | input | 1 | Delivered-performance tick enable |
| throttle_i | input | 1 | Suppresses the actual-performance tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Registered read data |
| cap_present_o | output | 1 | Capability flag, constant 1 |

## Verification
A register write can fall in the same cycle as a counting event. It can coincide with an increment of the same counter, or with an overflow of the other counter that would clear the one being written. The bench provokes both cases. It holds the tick inputs high during the write strobe, and it preloads the other counter to all-ones so that it wraps in exactly the write cycle. Afterwards the bench reads both counters back through the port. The written counter must hold exactly the write data, with no extra increment and no clear, and the other counter must be zero.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned DEF_CNT_W  = 64;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned NUM_CNT    = 2;

  typedef enum logic [0:0] {
    CNT_REF = 1'b0,
    CNT_ACT = 1'b1
  } cnt_idx_e;

  localparam logic [DEF_ADDR_W-1:0] DEF_REF_ADDR = 8'hE7;
  localparam logic [DEF_ADDR_W-1:0] DEF_ACT_ADDR = 8'hE8;
endpackage

// File: rtl/prc_tick_gate.sv
module prc_tick_gate (
  input  logic active_i,
  input  logic ref_tick_i,
  input  logic act_tick_i,
  input  logic throttle_i,
  output logic ref_inc_o,
  output logic act_inc_o
);
  // Both counters are frozen outside the active state; throttling
  // removes delivered-performance ticks only.
  assign ref_inc_o = active_i & ref_tick_i;
  assign act_inc_o = active_i & act_tick_i & ~throttle_i;
endmodule

// File: rtl/prc_counter.sv
module prc_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // Priority: load, then shared clear, then increment.
  function automatic logic [W-1:0] next_value(
    input logic [W-1:0] cur,
    input logic         inc,
    input logic         load,
    input logic [W-1:0] lval,
    input logic         clr
  );
    if (load)     return lval;
    else if (clr) return '0;
    else if (inc) return cur + W'(1);
    else          return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= next_value(cnt_q, inc_i, load_i, load_val_i, clr_i);
  end

  assign wrap_o = inc_i & (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/prc_regport.sv
module prc_regport #(
  parameter int unsigned          W        = 64,
  parameter int unsigned          AW       = 8,
  parameter int unsigned          N        = 2,
  parameter logic [AW-1:0]        REF_ADDR = 8'hE7,
  parameter logic [AW-1:0]        ACT_ADDR = 8'hE8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [N-1:0][W-1:0] cnt_i,
  output logic [N-1:0]        wr_sel_o,
  output logic [W-1:0]        rdata_o
);
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;

  function automatic logic [AW-1:0] addr_of(input int unsigned idx);
    return (idx == 0) ? REF_ADDR : ACT_ADDR;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign wr_sel_o[g] = wr_i & (addr_i == addr_of(g));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N; i++) begin
      if (addr_i == addr_of(i)) rd_mux = cnt_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/perf_ratio_counters.sv
module perf_ratio_counters
  import prc_pkg::*;
#(
  parameter int unsigned            CNT_W    = DEF_CNT_W,
  parameter int unsigned            ADDR_W   = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0]      REF_ADDR = DEF_REF_ADDR,
  parameter logic [ADDR_W-1:0]      ACT_ADDR = DEF_ACT_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              ref_tick_i,
  input  logic              act_tick_i,
  input  logic              throttle_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              cap_present_o
);
  logic [NUM_CNT-1:0]            inc_vec;
  logic [NUM_CNT-1:0]            wr_sel;
  logic [NUM_CNT-1:0]            wrap_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;

  // Named internal events for the checker.
  logic             ref_inc, act_inc;
  logic             wr_ref, wr_act;
  logic             wrap_any;
  logic [CNT_W-1:0] ref_cnt, act_cnt;

  prc_tick_gate u_gate (
    .active_i   (active_i),
    .ref_tick_i (ref_tick_i),
    .act_tick_i (act_tick_i),
    .throttle_i (throttle_i),
    .ref_inc_o  (ref_inc),
    .act_inc_o  (act_inc)
  );

  assign inc_vec[CNT_REF] = ref_inc;
  assign inc_vec[CNT_ACT] = act_inc;

  prc_regport #(
    .W        (CNT_W),
    .AW       (ADDR_W),
    .N        (NUM_CNT),
    .REF_ADDR (REF_ADDR),
    .ACT_ADDR (ACT_ADDR)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .cnt_i    (cnt_vec),
    .wr_sel_o (wr_sel),
    .rdata_o  (reg_rdata_o)
  );

  assign wrap_any = |wrap_vec;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    prc_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .inc_i      (inc_vec[g]),
      .load_i     (wr_sel[g]),
      .load_val_i (reg_wdata_i),
      .clr_i      (wrap_any),
      .cnt_o      (cnt_vec[g]),
      .wrap_o     (wrap_vec[g])
    );
  end

  assign wr_ref  = wr_sel[CNT_REF];
  assign wr_act  = wr_sel[CNT_ACT];
  assign ref_cnt = cnt_vec[CNT_REF];
  assign act_cnt = cnt_vec[CNT_ACT];

  assign cap_present_o = 1'b1;
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int unsigned       W        = 64,
  parameter int unsigned       AW       = 8,
  parameter logic [AW-1:0]     REF_ADDR = 8'hE7,
  parameter logic [AW-1:0]     ACT_ADDR = 8'hE8
) (
  input logic          clk,
  input logic          rst,
  input logic          active,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  reg_rdata,
  input logic [W-1:0]  ref_cnt,
  input logic [W-1:0]  act_cnt,
  input logic          ref_inc,
  input logic          act_inc,
  input logic          wr_ref,
  input logic          wr_act,
  input logic          wrap_any
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ref_cnt == '0 && act_cnt == '0 && reg_rdata == '0));

  assert_ref_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_inc && !wr_ref && !wrap_any) |=> ref_cnt == $past(ref_cnt) + W'(1));

  assert_act_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!act_inc && !wr_act && !wrap_any) |=> $stable(act_cnt));

  assert_idle_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!ref_inc && !act_inc));

  assert_coupled_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wrap_any && !wr_ref && !wr_act) |=> (ref_cnt == '0 && act_cnt == '0));

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ref |=> ref_cnt == $past(reg_wdata));

  assert_write_vs_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_ref && !wr_act && wrap_any) |=> act_cnt == '0);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ACT_ADDR) |=> reg_rdata == $past(act_cnt));

  assert_bad_read_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != REF_ADDR && reg_addr != ACT_ADDR) |=> reg_rdata == '0);
endmodule

bind perf_ratio_counters prc_checker #(
  .W        (CNT_W),
  .AW       (ADDR_W),
  .REF_ADDR (REF_ADDR),
  .ACT_ADDR (ACT_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .active    (active_i),
  .reg_rd    (reg_rd_i),
  .reg_addr  (reg_addr_i),
  .reg_wdata (reg_wdata_i),
  .reg_rdata (reg_rdata_o),
  .ref_cnt   (ref_cnt),
  .act_cnt   (act_cnt),
  .ref_inc   (ref_inc),
  .act_inc   (act_inc),
  .wr_ref    (wr_ref),
  .wr_act    (wr_act),
  .wrap_any  (wrap_any)
);

// File: tb/tb_perf_ratio_counters.sv
module tb_perf_ratio_counters;
  localparam logic [7:0]  A_REF = 8'hE7;
  localparam logic [7:0]  A_ACT = 8'hE8;
  localparam logic [63:0] ONES  = {64{1'b1}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        active_i = 1'b0, ref_tick_i = 1'b0, act_tick_i = 1'b0, throttle_i = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;
  logic        cap_present_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  perf_ratio_counters dut (
    .clk(clk), .rst(rst), .active_i(active_i), .ref_tick_i(ref_tick_i),
    .act_tick_i(act_tick_i), .throttle_i(throttle_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .cap_present_o(cap_present_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_ticks(input logic a, input logic r, input logic t, input logic th);
    active_i = a; ref_tick_i = r; act_tick_i = t; throttle_i = th;
  endtask

  task automatic run(input int n, input logic a, input logic r, input logic t, input logic th);
    set_ticks(a, r, t, th);
    repeat (n) @(negedge clk);
    set_ticks(0, 0, 0, 0);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [63:0] data);
    reg_wr_i = 1'b1; reg_addr_i = addr; reg_wdata_i = data;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [63:0] got);
    reg_rd_i = 1'b1; reg_addr_i = addr;
    @(negedge clk);
    reg_rd_i = 1'b0;
    got = reg_rdata_o;
  endtask

  task automatic clear_both();
    wr(A_REF, '0);
    wr(A_ACT, '0);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R1 rdata after reset", reg_rdata_o, '0);
    check("R10 capability flag", {63'b0, cap_present_o}, 64'd1);
    rd(A_REF, v); check("R1 ref after reset", v, '0);
    rd(A_ACT, v); check("R1 act after reset", v, '0);
  endtask

  task automatic t_ref_count();
    logic [63:0] v;
    clear_both();
    run(5, 1, 1, 0, 0);
    rd(A_REF, v); check("R2 ref counted 5", v, 64'd5);
    rd(A_ACT, v); check("R3 act idle without tick", v, 64'd0);
  endtask

  task automatic t_act_count();
    logic [63:0] v;
    clear_both();
    run(4, 1, 0, 1, 0);
    run(3, 1, 0, 1, 1);
    rd(A_ACT, v); check("R3 act counts unthrottled only", v, 64'd4);
    rd(A_REF, v); check("R2 ref idle without tick", v, 64'd0);
  endtask

  task automatic t_gate();
    logic [63:0] v;
    clear_both();
    run(2, 1, 1, 1, 0);
    run(6, 0, 1, 1, 0);
    rd(A_REF, v); check("R4 ref frozen when inactive", v, 64'd2);
    rd(A_ACT, v); check("R4 act frozen when inactive", v, 64'd2);
  endtask

  task automatic t_overflow();
    logic [63:0] v;
    wr(A_ACT, ONES);
    wr(A_REF, 64'd100);
    run(1, 1, 1, 1, 0);
    rd(A_REF, v); check("R5 act wrap clears ref", v, '0);
    rd(A_ACT, v); check("R5 act wrap clears act", v, '0);
    wr(A_REF, ONES);
    wr(A_ACT, 64'd50);
    run(1, 1, 1, 0, 0);
    rd(A_ACT, v); check("R5 ref wrap clears act", v, '0);
    rd(A_REF, v); check("R5 ref wrap clears ref", v, '0);
    run(3, 1, 1, 1, 0);
    rd(A_REF, v); check("R5 ref resumes after wrap", v, 64'd3);
    rd(A_ACT, v); check("R5 act resumes after wrap", v, 64'd3);
  endtask

  task automatic t_write_wins();
    logic [63:0] v;
    clear_both();
    set_ticks(1, 1, 1, 0);
    wr(A_REF, 64'd1000);
    set_ticks(0, 0, 0, 0);
    rd(A_REF, v); check("R6 write beats increment", v, 64'd1000);
    rd(A_ACT, v); check("R3 act ticked during other write", v, 64'd1);
  endtask

  task automatic t_write_vs_wrap();
    logic [63:0] v;
    wr(A_ACT, ONES);
    wr(A_REF, 64'd5);
    set_ticks(1, 0, 1, 0);
    wr(A_REF, 64'd777);
    set_ticks(0, 0, 0, 0);
    rd(A_REF, v); check("R7 written counter keeps data", v, 64'd777);
    rd(A_ACT, v); check("R7 wrapping counter cleared", v, '0);
  endtask

  task automatic t_read_timing();
    logic [63:0] v;
    wr(A_REF, 64'd10);
    set_ticks(1, 1, 0, 0);
    rd(A_REF, v); check("R8 value at strobe edge", v, 64'd10);
    @(negedge clk); @(negedge clk);
    set_ticks(0, 0, 0, 0);
    check("R8 rdata holds between strobes", reg_rdata_o, 64'd10);
    rd(A_REF, v); check("R8 later read sees count", v, 64'd13);
  endtask

  task automatic t_bad_addr();
    logic [63:0] v;
    wr(A_REF, 64'd42);
    wr(A_ACT, 64'd43);
    wr(8'hE9, 64'd123);
    wr(8'h00, 64'd321);
    rd(8'hE9, v); check("R9 unmapped read E9", v, '0);
    rd(8'h00, v); check("R9 unmapped read 00", v, '0);
    rd(A_REF, v); check("R9 ref untouched", v, 64'd42);
    rd(A_ACT, v); check("R9 act untouched", v, 64'd43);
  endtask

  initial begin
    check("R10 capability during reset", {63'b0, cap_present_o}, 64'd1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ref_count();
    t_act_count();
    t_gate();
    t_overflow();
    t_write_wins();
    t_write_vs_wrap();
    t_read_timing();
    t_bad_addr();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule